// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-ported storage array and watches the requests coming from its two independent ports, called left and right. Each port presents an enable, an address and a write strobe. When both ports are enabled on the same address, the block decides which of them keeps the location. It raises a busy flag towards the other port and withdraws that port's write permit for as long as the collision lasts. The port that reached the location first keeps it. If both arrive in the same cycle, a toggle bit picks the winner and alternates it from one tie to the next.

A strap input selects the mode. In master mode the block runs the arbitration itself and its busy outputs carry the result. In slave mode the block does not arbitrate. Its busy outputs follow busy signals imported from a master device, so several arrays can be ganged into a wider word and all of them obey one decision. A slave also withholds the write permit until the imported busy has been low for two consecutive cycles. Everything is synchronous to one clock, and the busy and permit outputs respond in the same cycle as the port inputs.

Top module: `dpa_contention_arbiter`

## Requirements
- R1: In master mode a busy output is high only while both enables are high and the two addresses are equal. Otherwise both busy outputs are low.
- R2: A port's access starts in the cycle its enable rises or, while enabled, its address changes. On a collision, the port whose access started earlier keeps the location. The port that arrived later sees its busy high in the first cycle of the collision.
- R3: When both accesses start in the same cycle (a tie), the right port wins if the toggle bit is 0 and the left port wins if it is 1. The toggle bit is 0 after reset and inverts after every tie resolved in master mode.
- R4: The winner keeps the location, and the loser's busy stays high, as long as the winner stays enabled on an unchanged address. This holds even when the loser drops its enable and asserts it again.
- R5: Busy clears in the same cycle that the addresses differ or either enable goes low.
- R6: In master mode the two busy outputs are never high together.
- R7: In slave mode each busy output equals the matching imported busy input, whatever the addresses are.
- R8: In master mode a port's write permit is high exactly when its enable and write strobe are high and its busy is low.
- R9: In slave mode a port's write permit is high exactly when its enable and write strobe are high and its imported busy is low both in this cycle and in the previous cycle.
- R10: With both ports idle after reset, both busy outputs and both write permits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | Mode strap: 1 = master (arbitrate), 0 = slave (import busy) |
| left_en_i | input | 1 | Left port enable |
| left_addr_i | input | AW | Left port address |
| left_we_i | input | 1 | Left port write strobe |
| right_en_i | input | 1 | Right port enable |
| right_addr_i | input | AW | Right port address |
| right_we_i | input | 1 | Right port write strobe |
| left_busy_ext_i | input | 1 | Busy for the left port, imported from a master (slave mode) |
| right_busy_ext_i | input | 1 | Busy for the right port, imported from a master (slave mode) |
| left_busy_o | output | 1 | Busy towards the left port, active high |
| right_busy_o | output | 1 | Busy towards the right port, active high |
| left_wr_ok_o | output | 1 | Left port write permit |
| right_wr_ok_o | output | 1 | Right port write permit |

## Verification
The bench drives staggered arrivals from each side. A design that ignored arrival order would flag the port that already held the location. It drives back-to-back same-cycle ties, which expose a toggle that never inverts or that starts with the wrong side. It also drives a loser that releases and re-asserts its enable, and a winner that moves its address. A design that handed ownership to whoever asserted last, or that kept a stale owner, would raise busy on the wrong port. In slave mode it pulses the imported busy for a single cycle, so a design that permits the write while that busy is still settling shows a stray write permit.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int unsigned NPORTS = 2;
  localparam int unsigned P_LEFT  = 0;
  localparam int unsigned P_RIGHT = 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpa_port_track.sv
// Flags the cycle in which a port starts a new access (enable rise or address move).
module dpa_port_track #(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic          fresh_o
);
  logic          en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_i;
      addr_q <= addr_i;
    end
  end

  assign fresh_o = en_i && (!en_q || (addr_i != addr_q));
endmodule

// File: rtl/dpa_busy_settle.sv
// Slave side: permit only once the imported busy has been low for two cycles.
module dpa_busy_settle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_ext_i,
  output logic quiet_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_ext_i;
  end

  assign quiet_o = !busy_ext_i && !busy_q;
endmodule

// File: rtl/dpa_arbiter_core.sv
module dpa_arbiter_core
  import dpa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arb_en_i,
  input  logic              match_i,
  input  logic [NPORTS-1:0] fresh_i,
  output owner_e            win_o
);
  owner_e owner_q;
  logic   tie_q;
  logic   tie;

  always_comb begin
    win_o = OWN_NONE;
    tie   = 1'b0;
    if (arb_en_i && match_i) begin
      if (owner_q == OWN_LEFT && !fresh_i[P_LEFT])
        win_o = OWN_LEFT;
      else if (owner_q == OWN_RIGHT && !fresh_i[P_RIGHT])
        win_o = OWN_RIGHT;
      else if (fresh_i[P_LEFT] && !fresh_i[P_RIGHT])
        win_o = OWN_RIGHT;   // right was there first
      else if (fresh_i[P_RIGHT] && !fresh_i[P_LEFT])
        win_o = OWN_LEFT;
      else begin
        tie   = 1'b1;
        win_o = tie_q ? OWN_LEFT : OWN_RIGHT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_NONE;
      tie_q   <= 1'b0;
    end else begin
      owner_q <= win_o;
      if (tie) tie_q <= ~tie_q;
    end
  end
endmodule

// File: rtl/dpa_contention_arbiter.sv
module dpa_contention_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          left_en_i,
  input  logic [AW-1:0] left_addr_i,
  input  logic          left_we_i,
  input  logic          right_en_i,
  input  logic [AW-1:0] right_addr_i,
  input  logic          right_we_i,
  input  logic          left_busy_ext_i,
  input  logic          right_busy_ext_i,
  output logic          left_busy_o,
  output logic          right_busy_o,
  output logic          left_wr_ok_o,
  output logic          right_wr_ok_o
);
  logic [NPORTS-1:0] en_v, we_v, ext_v, fresh_v, quiet_v, busy_v, wr_v;
  logic [AW-1:0]     addr_v [NPORTS];
  logic              match;
  owner_e            win;

  assign en_v  = {right_en_i, left_en_i};
  assign we_v  = {right_we_i, left_we_i};
  assign ext_v = {right_busy_ext_i, left_busy_ext_i};
  assign addr_v[P_LEFT]  = left_addr_i;
  assign addr_v[P_RIGHT] = right_addr_i;

  assign match = en_v[P_LEFT] && en_v[P_RIGHT] &&
                 (addr_v[P_LEFT] == addr_v[P_RIGHT]);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam owner_e RIVAL = (p == P_LEFT) ? OWN_RIGHT : OWN_LEFT;

    dpa_port_track #(.AW(AW)) u_track (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_v[p]),
      .addr_i  (addr_v[p]),
      .fresh_o (fresh_v[p])
    );

    dpa_busy_settle u_settle (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .busy_ext_i (ext_v[p]),
      .quiet_o    (quiet_v[p])
    );

    assign busy_v[p] = master_i ? (win == RIVAL) : ext_v[p];
    assign wr_v[p]   = en_v[p] && we_v[p] &&
                       (master_i ? !busy_v[p] : quiet_v[p]);
  end

  dpa_arbiter_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arb_en_i (master_i),
    .match_i  (match),
    .fresh_i  (fresh_v),
    .win_o    (win)
  );

  assign left_busy_o   = busy_v[P_LEFT];
  assign right_busy_o  = busy_v[P_RIGHT];
  assign left_wr_ok_o  = wr_v[P_LEFT];
  assign right_wr_ok_o = wr_v[P_RIGHT];
endmodule

// File: rtl/dpa_contention_arbiter_sva.sv
module dpa_contention_arbiter_sva #(
  parameter int unsigned AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          master_i,
  input logic          left_en_i,
  input logic [AW-1:0] left_addr_i,
  input logic          left_we_i,
  input logic          right_en_i,
  input logic [AW-1:0] right_addr_i,
  input logic          right_we_i,
  input logic          left_busy_ext_i,
  input logic          right_busy_ext_i,
  input logic          left_busy_o,
  input logic          right_busy_o,
  input logic          left_wr_ok_o,
  input logic          right_wr_ok_o
);
  logic same;
  assign same = left_en_i && right_en_i && (left_addr_i == right_addr_i);

  a_r1_busy_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !same) |-> (!left_busy_o && !right_busy_o));

  a_r6_busy_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> !(left_busy_o && right_busy_o));

  a_r2_one_loser: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && same) |-> $countones({left_busy_o, right_busy_o}) == 1);

  a_r4_left_stays_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $past(left_busy_o) && same &&
     $past(right_en_i) && $stable(right_addr_i)) |-> left_busy_o);

  a_r4_right_stays_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $past(right_busy_o) && same &&
     $past(left_en_i) && $stable(left_addr_i)) |-> right_busy_o);

  a_r8_left_no_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_busy_o |-> !left_wr_ok_o);

  a_r8_right_no_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_busy_o |-> !right_wr_ok_o);

  a_r7_slave_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (left_busy_o == left_busy_ext_i && right_busy_o == right_busy_ext_i));

  a_r9_slave_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && $past(left_busy_ext_i)) |-> !left_wr_ok_o);
endmodule

bind dpa_contention_arbiter dpa_contention_arbiter_sva #(.AW(AW)) u_sva (.*);

// File: tb/dpa_contention_arbiter_test.sv
module dpa_contention_arbiter_test;
  localparam int unsigned AW = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i = 1'b1;
  logic left_en_i = 1'b0, right_en_i = 1'b0, left_we_i = 1'b0, right_we_i = 1'b0;
  logic [AW-1:0] left_addr_i = '0, right_addr_i = '0;
  logic left_busy_ext_i = 1'b0, right_busy_ext_i = 1'b0;
  logic left_busy_o, right_busy_o, left_wr_ok_o, right_wr_ok_o;

  int checks = 0;
  int errors = 0;

  // reference model state: owner 0 none, 1 left, 2 right
  int m_own = 0, m_tog = 0;
  int pl_en = 0, pr_en = 0, pl_a = 0, pr_a = 0;
  int lq = 0, rq = 0;

  always #10 clk = ~clk;

  dpa_contention_arbiter #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i),
    .left_en_i(left_en_i), .left_addr_i(left_addr_i), .left_we_i(left_we_i),
    .right_en_i(right_en_i), .right_addr_i(right_addr_i), .right_we_i(right_we_i),
    .left_busy_ext_i(left_busy_ext_i), .right_busy_ext_i(right_busy_ext_i),
    .left_busy_o(left_busy_o), .right_busy_o(right_busy_o),
    .left_wr_ok_o(left_wr_ok_o), .right_wr_ok_o(right_wr_ok_o)
  );

  task automatic decide(output int win, output int tie);
    int la, ra, ln, rn, clash;
    la = int'(left_addr_i); ra = int'(right_addr_i);
    clash = (left_en_i && right_en_i && la == ra) ? 1 : 0;
    ln = (left_en_i && (pl_en == 0 || la != pl_a)) ? 1 : 0;
    rn = (right_en_i && (pr_en == 0 || ra != pr_a)) ? 1 : 0;
    win = 0; tie = 0;
    if (master_i && clash != 0) begin
      if (m_own == 1 && ln == 0)      win = 1;
      else if (m_own == 2 && rn == 0) win = 2;
      else if (ln != rn)              win = ln ? 2 : 1;
      else begin tie = 1; win = (m_tog != 0) ? 1 : 2; end
    end
  endtask

  always @(posedge clk) begin
    int w, t;
    if (!rst_ni) begin
      m_own = 0; m_tog = 0; pl_en = 0; pr_en = 0; pl_a = 0; pr_a = 0; lq = 0; rq = 0;
    end else begin
      decide(w, t);
      m_own = w;
      if (t != 0) m_tog = 1 - m_tog;
      pl_en = left_en_i; pr_en = right_en_i;
      pl_a = int'(left_addr_i); pr_a = int'(right_addr_i);
      lq = left_busy_ext_i; rq = right_busy_ext_i;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int w, t;
    logic eb_l, eb_r, ew_l, ew_r;
    decide(w, t);
    if (master_i) begin
      eb_l = (w == 2); eb_r = (w == 1);
      ew_l = left_en_i && left_we_i && !eb_l;
      ew_r = right_en_i && right_we_i && !eb_r;
    end else begin
      eb_l = left_busy_ext_i; eb_r = right_busy_ext_i;
      ew_l = left_en_i && left_we_i && !left_busy_ext_i && (lq == 0);
      ew_r = right_en_i && right_we_i && !right_busy_ext_i && (rq == 0);
    end
    chk(tag, "left_busy", left_busy_o, eb_l);
    chk(tag, "right_busy", right_busy_o, eb_r);
    chk(tag, "left_wr_ok", left_wr_ok_o, ew_l);
    chk(tag, "right_wr_ok", right_wr_ok_o, ew_r);
  endtask

  task automatic cyc(input string tag, input logic mst,
                     input logic le, input int la, input logic lw,
                     input logic re, input int ra, input logic rw,
                     input logic lx, input logic rx);
    @(negedge clk);
    master_i = mst;
    left_en_i = le; left_addr_i = la[AW-1:0]; left_we_i = lw;
    right_en_i = re; right_addr_i = ra[AW-1:0]; right_we_i = rw;
    left_busy_ext_i = lx; right_busy_ext_i = rx;
    #5 compare(tag);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10 reset state
    cyc("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1, R8: different addresses, both write
    cyc("R1", 1, 1, 3, 1, 1, 4, 1, 0, 0);
    cyc("R8", 1, 1, 3, 1, 1, 4, 1, 0, 0);
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: left first, right joins -> right busy
    cyc("R2", 1, 1, 5, 1, 0, 0, 0, 0, 0);
    cyc("R2", 1, 1, 5, 1, 1, 5, 1, 0, 0);
    cyc("R4", 1, 1, 5, 1, 1, 5, 1, 0, 0);
    // R4: right retries
    cyc("R4", 1, 1, 5, 1, 0, 5, 1, 0, 0);
    cyc("R4", 1, 1, 5, 1, 1, 5, 1, 0, 0);
    // R5: right moves away, then left releases
    cyc("R5", 1, 1, 5, 1, 1, 6, 1, 0, 0);
    cyc("R5", 1, 1, 6, 1, 1, 6, 1, 0, 0);
    cyc("R5", 1, 0, 6, 1, 1, 6, 1, 0, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: right first, left joins -> left busy
    cyc("R2", 1, 0, 0, 0, 1, 9, 1, 0, 0);
    cyc("R2", 1, 1, 9, 1, 1, 9, 1, 0, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3: ties alternate, first one won by right
    cyc("R3", 1, 1, 7, 1, 1, 7, 1, 0, 0);
    cyc("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R3", 1, 1, 8, 1, 1, 8, 1, 0, 0);
    cyc("R3", 1, 1, 8, 1, 1, 8, 1, 0, 0);
    cyc("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R3", 1, 1, 2, 0, 1, 2, 0, 0, 0);
    // R2: winner (right) moves onto a new address shared with left
    cyc("R2", 1, 1, 2, 1, 1, 3, 1, 0, 0);
    cyc("R2", 1, 1, 2, 1, 1, 2, 1, 0, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7, R9: slave mode
    cyc("R7", 0, 1, 4, 1, 1, 4, 1, 0, 0);
    cyc("R7", 0, 1, 4, 1, 1, 4, 1, 1, 0);
    cyc("R9", 0, 1, 4, 1, 1, 4, 1, 0, 0);
    cyc("R9", 0, 1, 4, 1, 1, 4, 1, 0, 1);
    cyc("R9", 0, 1, 4, 1, 1, 4, 1, 0, 0);
    cyc("R9", 0, 1, 4, 1, 1, 4, 1, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // mixed stimulus over a small address range, both modes
    for (int i = 0; i < 600; i++) begin
      logic mst;
      mst = (i < 400) ? 1'b1 : 1'b0;
      cyc(mst ? "R6" : "R9", mst,
          ($urandom_range(3) != 0), int'($urandom_range(2)), $urandom_range(1) != 0,
          ($urandom_range(3) != 0), int'($urandom_range(2)), $urandom_range(1) != 0,
          ($urandom_range(2) == 0), ($urandom_range(2) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule